// File: doc/BRIEF.md
# Clock Divider Bank with Crosspoint Routing

This block is the output stage of a clock generator. Four internal clock sources reach it, and a crosspoint routes any one of them to each of four post dividers, named A, B, C and D. Each divider divides its source by a 7-bit programmable ratio. Dividers A and B each keep two stored ratios. A 3-bit select input, passed through two synchroniser flops and then through an eight-entry programmable lookup, picks which of the two stored ratios both dividers use. Dividers C and D each have a single ratio.

In this model every source is a one-cycle clock-enable pulse stream in the domain of one system clock, and each divider output is a registered level. A ratio change, whether it comes from a register write or from the select input, is held back until the running output period ends. The output therefore never shows a shortened high or low phase. A simple write port with an address and data loads all settings.

Top module: `cdb_divider_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every output is low. All settings start at zero: every route selects source 0, every lookup entry selects ratio register 0, and every ratio is 0.
- R2: A write to address 0 sets the crosspoint. Bits [1:0] route to A, [3:2] to B, [5:4] to C and [7:6] to D. The field value n selects src_en[n] as that divider's tick.
- R3: With an active ratio N >= 2, each output period spans N ticks of its source. The output is high for the first floor(N/2) ticks of the period and low for the rest. The output is updated on the clock edge that samples the tick.
- R4: With an active ratio of 1, the output is high in the cycle after each sampled tick and low otherwise.
- R5: With an active ratio of 0, the output stays low.
- R6: Address 1 holds the lookup: bit k gives the ratio-register index for select value k. Index 0 makes A use address 2 and B use address 4. Index 1 makes A use address 3 and B use address 5. A and B always use the same index.
- R7: The select input is sampled through two flops. A value presented before clock edge j takes part in the lookup from edge j+2 onward.
- R8: A new ratio is taken up only on the tick that ends the current period, or on any tick while the active ratio is 0 or 1. Until then the old ratio runs to completion.
- R9: Dividers C and D take their ratios only from addresses 6 and 7. The select input and the lookup do not affect them.
- R10: Ratio registers take wr_data[6:0]. A write lands on the clock edge where wr_en is high and counts for ticks from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_en | input | 4 | Clock-enable pulse streams of the four sources |
| sel | input | 3 | Asynchronous ratio select for dividers A and B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| clk_out | output | 4 | Divided outputs, bit 0 = A, 1 = B, 2 = C, 3 = D |

## Verification
Two events can collide in one cycle: the synchronised select index flips, or a ratio write lands, on exactly the tick that closes an output period. The same tick also has to load the new ratio and start the next period. The bench provokes this in two ways. In directed cases it changes select and writes ratios at chosen offsets inside a period. In a long random run it changes routing, lookup, ratios and select at arbitrary points. A model built from the requirements predicts the level of every output in every cycle, and the bench compares it against clk_out, so a ratio taken up early or late shows as a runt or stretched phase.

// File: rtl/cdb_pkg.sv
`timescale 1ns/1ps
package cdb_pkg;
  localparam int unsigned NUM_OUT  = 4;
  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned SRC_W    = $clog2(NUM_SRC);
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_DIVR = 6;   // A0, A1, B0, B1, C, D
  localparam int unsigned DIV_BASE = 2;   // address of first ratio register

  typedef enum logic [ADDR_W-1:0] {
    ADR_ROUTE = 3'd0,
    ADR_LUT   = 3'd1
  } cdb_addr_e;
endpackage

// File: rtl/cdb_rst_sync.sv
`timescale 1ns/1ps
module cdb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/cdb_cfg_regs.sv
`timescale 1ns/1ps
module cdb_cfg_regs
  import cdb_pkg::*;
#(
  parameter int unsigned DIV_W = 7,
  parameter int unsigned LUT_N = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_OUT*SRC_W-1:0]   route,
  output logic [LUT_N-1:0]           lut,
  output logic [DIV_W-1:0]           div_reg [NUM_DIVR]
);
  localparam int unsigned ROUTE_W = NUM_OUT * SRC_W;

  logic [ROUTE_W-1:0] route_q, route_d;
  logic [LUT_N-1:0]   lut_q, lut_d;

  // Crosspoint and lookup registers
  always_comb begin
    route_d = route_q;
    lut_d   = lut_q;
    if (wr_en && (wr_addr == ADR_ROUTE)) route_d = wr_data[ROUTE_W-1:0];
    if (wr_en && (wr_addr == ADR_LUT))   lut_d   = wr_data[LUT_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      lut_q   <= '0;
    end else begin
      route_q <= route_d;
      lut_q   <= lut_d;
    end
  end

  // Ratio registers, one per address
  for (genvar g = 0; g < NUM_DIVR; g++) begin : g_div
    logic [DIV_W-1:0] ratio_q, ratio_d;
    logic             hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(DIV_BASE + g));

    always_comb begin
      ratio_d = ratio_q;
      if (hit) ratio_d = wr_data[DIV_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ratio_q <= '0;
      else        ratio_q <= ratio_d;
    end

    assign div_reg[g] = ratio_q;
  end

  assign route = route_q;
  assign lut   = lut_q;
endmodule

// File: rtl/cdb_sel_lookup.sv
`timescale 1ns/1ps
module cdb_sel_lookup #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned LUT_N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_async,
  input  logic [LUT_N-1:0] lut,
  output logic             bank_idx
);
  logic [SEL_W-1:0] meta_q, meta_d;
  logic [SEL_W-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = sel_async;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign bank_idx = lut[sync_q];
endmodule

// File: rtl/cdb_post_div.sv
`timescale 1ns/1ps
module cdb_post_div #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] ratio_next,
  output logic             div_out,
  output logic [DIV_W-1:0] ratio_act,
  output logic [DIV_W-1:0] phase
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] act_q, act_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             period_end;

  // A period closes on its last tick; ratios 0 and 1 close on every tick
  assign period_end = (act_q <= ONE) || (cnt_q >= act_q - ONE);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (tick) begin
      if (period_end) begin
        cnt_d = '0;
        act_d = ratio_next;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
    if (act_d == '0)      out_d = 1'b0;
    else if (act_d == ONE) out_d = tick;
    else                   out_d = (cnt_d < (act_d >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign div_out   = out_q;
  assign ratio_act = act_q;
  assign phase     = cnt_q;
endmodule

// File: rtl/cdb_divider_bank.sv
`timescale 1ns/1ps
module cdb_divider_bank
  import cdb_pkg::*;
#(
  parameter int unsigned DIV_W = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [SEL_W-1:0]   sel,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_OUT-1:0] clk_out
);
  localparam int unsigned LUT_N = 1 << SEL_W;

  logic                       rst_sync_n;
  logic [NUM_OUT*SRC_W-1:0]   route;
  logic [LUT_N-1:0]           lut;
  logic [DIV_W-1:0]           div_reg [NUM_DIVR];
  logic                       bank_idx;
  logic [NUM_OUT-1:0]         tick;
  logic [DIV_W-1:0]           pend    [NUM_OUT];
  logic [DIV_W-1:0]           div_act [NUM_OUT];
  logic [DIV_W-1:0]           div_cnt [NUM_OUT];

  cdb_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdb_cfg_regs #(.DIV_W(DIV_W), .LUT_N(LUT_N)) i_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .route   (route),
    .lut     (lut),
    .div_reg (div_reg)
  );

  cdb_sel_lookup #(.SEL_W(SEL_W), .LUT_N(LUT_N)) i_sel (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_async (sel),
    .lut       (lut),
    .bank_idx  (bank_idx)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    // Crosspoint: route field picks the source tick
    assign tick[g] = src_en[route[g*SRC_W +: SRC_W]];

    // Ratio source: A and B share the banked index, C and D are fixed
    if (g == 0) begin : g_bank_a
      assign pend[g] = bank_idx ? div_reg[1] : div_reg[0];
    end else if (g == 1) begin : g_bank_b
      assign pend[g] = bank_idx ? div_reg[3] : div_reg[2];
    end else begin : g_fixed
      assign pend[g] = div_reg[g + 2];
    end

    cdb_post_div #(.DIV_W(DIV_W)) i_div (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .tick       (tick[g]),
      .ratio_next (pend[g]),
      .div_out    (clk_out[g]),
      .ratio_act  (div_act[g]),
      .phase      (div_cnt[g])
    );
  end
endmodule

// File: rtl/cdb_divider_bank_chk.sv
`timescale 1ns/1ps
module cdb_divider_bank_chk
  import cdb_pkg::*;
#(
  parameter int unsigned DIV_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_OUT-1:0] tick,
  input logic [NUM_OUT-1:0] clk_out,
  input logic [DIV_W-1:0]   act [NUM_OUT],
  input logic [DIV_W-1:0]   cnt [NUM_OUT]
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    // R8: the active ratio only moves on a tick
    p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[g] |=> $stable(act[g]));

    // R5: a high output needs a nonzero active ratio
    p_low_when_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clk_out[g] |-> (act[g] != '0));

    // R3: an output rises only on the edge that samples a tick
    p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out[g]) |-> $past(tick[g]));

    // R3: position within the period stays below the ratio
    p_phase_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == '0) || (cnt[g] < act[g]));
  end
endmodule

bind cdb_divider_bank cdb_divider_bank_chk #(.DIV_W(DIV_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick    (tick),
  .clk_out (clk_out),
  .act     (div_act),
  .cnt     (div_cnt)
);

// File: tb/test_cdb_divider_bank.sv
`timescale 1ns/1ps
module test_cdb_divider_bank;
  logic       clk;
  logic       rst_n;
  logic [3:0] src_en;
  logic [2:0] sel;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] clk_out;

  cdb_divider_bank i_cdb_divider_bank (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .sel(sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clk_out(clk_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // Requirement-level model state
  int         m_len  [4];
  int         m_pos  [4];
  int         m_ratio[6];
  logic [7:0] m_route;
  logic [7:0] m_lut;
  logic [2:0] m_s1, m_s2;
  int         cyc = 0;

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin m_len[i] = 0; m_pos[i] = 0; end
    for (int i = 0; i < 6; i++) m_ratio[i] = 0;
    m_route = '0; m_lut = '0; m_s1 = '0; m_s2 = '0;
  endtask

  // One clock of stimulus plus its predicted outputs
  task automatic drive(input logic [3:0] s_en, input logic [2:0] s,
                       input logic we, input logic [2:0] a,
                       input logic [7:0] d, input string tag);
    item_t it;
    int    bank;
    int    want;
    logic  tk;
    @(negedge clk);
    rst_n = 1'b1; src_en = s_en; sel = s; wr_en = we; wr_addr = a; wr_data = d;
    bank = int'(m_lut[m_s2]);
    for (int i = 0; i < 4; i++) begin
      want = (i == 0) ? m_ratio[bank] : (i == 1) ? m_ratio[2 + bank] : m_ratio[i + 2];
      tk   = s_en[m_route[2*i +: 2]];
      if (tk) begin
        if (m_len[i] <= 1 || m_pos[i] + 1 >= m_len[i]) begin
          m_len[i] = want; m_pos[i] = 0;
        end else begin
          m_pos[i] = m_pos[i] + 1;
        end
      end
      if (m_len[i] == 0)      it.exp[i] = 1'b0;
      else if (m_len[i] == 1) it.exp[i] = tk;
      else                    it.exp[i] = (m_pos[i] < m_len[i] / 2);
    end
    it.tag = tag;
    q.push_back(it);
    m_s2 = m_s1; m_s1 = s;
    if (we) begin
      if (a == 3'd0)      m_route = d;
      else if (a == 3'd1) m_lut = d;
      else                m_ratio[int'(a) - 2] = int'(d[6:0]);
    end
    cyc++;
  endtask

  function automatic logic [3:0] pat(input int c);
    pat[0] = 1'b1;
    pat[1] = (c % 2) == 0;
    pat[2] = (c % 3) == 0;
    pat[3] = ($urandom % 2) == 1;
  endfunction

  task automatic run(input int n, input logic [2:0] s, input string tag);
    for (int k = 0; k < n; k++) drive(pat(cyc), s, 1'b0, 3'd0, 8'd0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [2:0] s, input string tag);
    drive(pat(cyc), s, 1'b1, a, d, tag);
  endtask

  // Monitor: compare each predicted item one step after its edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_vec++;
        if (clk_out !== it.exp) begin
          n_bad++;
          $display("FAIL %s: clk_out=%b expected %b (vector %0d)", it.tag, clk_out, it.exp, n_vec);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired, finished=0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_en = '0; sel = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    model_clear();
    // R1: outputs low while in reset
    for (int k = 0; k < 4; k++) begin
      item_t it;
      @(negedge clk);
      src_en = 4'hF;
      it.exp = 4'b0; it.tag = "R1";
      q.push_back(it);
    end
    // R1: internal reset release, defaults give low outputs
    run(6, 3'd0, "R1");
    // R5: ratios still zero, ticks on every source
    run(20, 3'd0, "R5");

    // R2 / R10: route A<-0, B<-1, C<-2, D<-3; program ratios
    wr(3'd0, 8'b11_10_01_00, 3'd0, "R2");
    wr(3'd2, 8'd4, 3'd0, "R10");
    wr(3'd3, 8'd3, 3'd0, "R10");
    wr(3'd4, 8'd5, 3'd0, "R10");
    wr(3'd5, 8'd2, 3'd0, "R10");
    wr(3'd6, 8'd1, 3'd0, "R4");
    wr(3'd7, 8'd7, 3'd0, "R10");
    run(60, 3'd0, "R3");

    // R6: lookup bit k = k[0]; select 1 chooses registers 3 and 5
    wr(3'd1, 8'b1010_1010, 3'd0, "R6");
    run(10, 3'd0, "R6");
    run(4, 3'd1, "R7");
    run(40, 3'd1, "R6");
    run(4, 3'd2, "R7");
    run(30, 3'd2, "R8");

    // R8: ratio written mid-period waits for the period end
    wr(3'd2, 8'd6, 3'd2, "R8");
    run(3, 3'd2, "R8");
    wr(3'd4, 8'd3, 3'd2, "R8");
    run(40, 3'd2, "R8");

    // R9: select and lookup toggling leave C and D alone
    wr(3'd6, 8'd3, 3'd0, "R9");
    wr(3'd1, 8'hFF, 3'd0, "R9");
    for (int k = 0; k < 40; k++) drive(pat(cyc), 3'(k), 1'b0, 3'd0, 8'd0, "R9");

    // R2: every output fed from source 3
    wr(3'd0, 8'b11_11_11_11, 3'd0, "R2");
    run(40, 3'd5, "R2");

    // R5: ratio 0 on register 0 holds A low
    wr(3'd1, 8'h00, 3'd0, "R5");
    wr(3'd2, 8'd0, 3'd0, "R5");
    run(30, 3'd0, "R5");

    // R4: ratio 1 on C with a sparse source
    wr(3'd0, 8'b00_10_01_00, 3'd0, "R4");
    wr(3'd6, 8'd1, 3'd0, "R4");
    run(20, 3'd0, "R4");

    // Random settings, select changes and writes at arbitrary points
    begin
      logic [2:0] s;
      s = 3'd0;
      for (int k = 0; k < 2500; k++) begin
        if (($urandom % 40) == 0) s = 3'($urandom);
        if (($urandom % 16) == 0) begin
          logic [2:0] a;
          logic [7:0] d;
          a = 3'($urandom);
          d = (a < 3'd2) ? 8'($urandom) : 8'($urandom % 12);
          drive(pat(cyc), s, 1'b1, a, d, "R8");
        end else begin
          drive(pat(cyc), s, 1'b0, 3'd0, 8'd0, "R3");
        end
      end
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule